// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single down-counting channel for an interval timer. A host loads a count value and selects one of eight operating codes. From then on the channel counts on every clock cycle on which the counter enable is high, and drives an output level whose shape depends on the operating code. The shapes are a level that rises at terminal count, a one-shot low pulse started by the gate, a periodic one-step low pulse, a square wave, and a single low strobe. The gate input can suspend counting in some codes and restart the count on its rising edge in others.

The output level also feeds an interrupt request. A mask input forces that request low while the output keeps running. When the mask is released, the request follows the output level again. Register decoding, decimal counting and the grouping of several channels belong to the surrounding logic.

Top module: `tmr_chan`

## Requirements
- R1: A load value of 0 stands for 65536. After such a load the visible 16-bit count reads 0, and the first counting step in codes 0, 1, 4 and 5 gives 65535.
- R2: A cycle with `load_stb` high places `load_val` in the count on that clock edge. This restarts counting from the new value, whatever count was running before.
- R3: In codes 0, 1, 4 and 5 each counting step lowers the count by one, and the count wraps from 0 to 65535.
- R4: In code 2 each counting step lowers the count by one. A step taken at count 1 reloads the loaded value instead. `out_lvl` is low exactly while the count is 1.
- R5: In code 3 each counting step lowers the count by two. A step taken at a count of 2 or less reloads the loaded value. `out_lvl` goes high at load and at gate restart, and it inverts on every reload. Even and odd loaded values behave the same way.
- R6: Code 6 behaves exactly as code 2, and code 7 behaves exactly as code 3.
- R7: A rising gate edge, seen one clock after the gate was low, reloads the count from the loaded value. This happens in codes 1, 2, 3, 5, 6 and 7. In codes 0 and 4 the edge has no effect beyond resuming counting.
- R8: A counting step happens only on a clock where `cnt_en` is high. In codes 0, 2, 3, 4, 6 and 7 the gate must also be high. Otherwise the count holds.
- R9: In code 0, `out_lvl` goes low at load. It goes high on the step that brings the count to 0, and it stays high until the next load.
- R10: In code 1, `out_lvl` is high after load. It goes low at a gate restart and high again at terminal count. In codes 4 and 5, `out_lvl` drops low for one counting step when the count first reaches 0. In code 4 this counts from the load; in code 5 it counts from a gate restart.
- R11: `irq` is `out_lvl` registered by one clock. It is 0 on the clock after any cycle with `irq_mask` high.
- R12: During reset, `count` is 0, `out_lvl` is 1 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter clock enable; one counting step per high cycle |
| load_stb | input | 1 | Load strobe for `load_val` |
| load_val | input | 16 | New count value (0 means 65536) |
| mode | input | 3 | Operating code 0 to 7 |
| gate | input | 1 | Gate level: enables counting or triggers a restart, depending on code |
| irq_mask | input | 1 | Forces `irq` low while high |
| count | output | 16 | Live count |
| out_lvl | output | 1 | Channel output level |
| irq | output | 1 | Interrupt request derived from `out_lvl` |

## Verification
The bench targets the zero-load case. A design that treats 0 literally would expire at once instead of running through 65535. It checks odd loaded values in the square-wave code, where a design that tests only for zero would count past 1 and wrap. It drives gate edges in a code that retriggers and in one that must not. A design that mixes the two groups either restarts code 0 or fails to restart code 2. It also checks the one-step strobe, which a design could hold low or repeat on wrap. Finally, it checks that the mask clears the request while the output stays high, and that the request returns after the mask is released.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    // Operating behaviour class, picked by the two low bits of the code.
    typedef enum logic [1:0] {
        CLS_ONESHOT   = 2'd0,
        CLS_TRIGGERED = 2'd1,
        CLS_RATE      = 2'd2,
        CLS_SQUARE    = 2'd3
    } op_class_e;

    function automatic op_class_e decode_class(input logic [2:0] code);
        return op_class_e'(code[1:0]);
    endfunction

    // Codes 4 and 5 give a single strobe instead of a level.
    function automatic logic is_strobe(input logic [2:0] code);
        return code[2] & ~code[1];
    endfunction

    // Gate level suspends counting in every class but the triggered one.
    function automatic logic gate_holds(input op_class_e cls);
        return cls != CLS_TRIGGERED;
    endfunction

    // Gate rising edge restarts counting in every class but the plain one-shot.
    function automatic logic gate_restarts(input op_class_e cls);
        return cls != CLS_ONESHOT;
    endfunction

endpackage

// File: rtl/tmr_gate_edge.sv
module tmr_gate_edge (
    input  logic clk,
    input  logic rst,
    input  logic gate,
    output logic rise
);
    logic gate_q;

    // Reset to high so a gate already high at reset release is not an edge.
    always_ff @(posedge clk) begin
        if (rst) gate_q <= 1'b1;
        else     gate_q <= gate;
    end

    assign rise = gate & ~gate_q;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  op_class_e        cls,
    input  logic             gate,
    input  logic             trig,
    output logic [CNT_W:0]   cnt_full,
    output logic             step,
    output logic             expire
);
    localparam logic [CNT_W:0] FULL_SPAN = {1'b1, {CNT_W{1'b0}}};
    localparam logic [CNT_W:0] ONE       = {{CNT_W{1'b0}}, 1'b1};
    localparam logic [CNT_W:0] TWO       = {{(CNT_W-1){1'b0}}, 2'b10};

    logic [CNT_W:0] reload_q, cnt_q, cnt_d, load_norm;
    logic           run;

    assign load_norm = (load_val == '0) ? FULL_SPAN : {1'b0, load_val};
    assign run       = cnt_en & (gate | ~gate_holds(cls));
    assign step      = run & ~load_stb & ~trig;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        unique case (cls)
            CLS_ONESHOT, CLS_TRIGGERED: begin
                cnt_d  = {1'b0, cnt_q[CNT_W-1:0] - 1'b1};
                expire = (cnt_q[CNT_W-1:0] == ONE[CNT_W-1:0]);
            end
            CLS_RATE: begin
                expire = (cnt_q == ONE);
                cnt_d  = expire ? reload_q : cnt_q - ONE;
            end
            CLS_SQUARE: begin
                expire = (cnt_q <= TWO);
                cnt_d  = expire ? reload_q : cnt_q - TWO;
            end
            default: ;
        endcase
        expire = expire & step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= FULL_SPAN;
            cnt_q    <= '0;
        end else if (load_stb) begin
            reload_q <= load_norm;
            cnt_q    <= load_norm;
        end else if (trig) begin
            cnt_q    <= reload_q;
        end else if (step) begin
            cnt_q    <= cnt_d;
        end
    end

    assign cnt_full = cnt_q;
endmodule

// File: rtl/tmr_out_shape.sv
module tmr_out_shape
    import tmr_chan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load_stb,
    input  logic      trig,
    input  logic      step,
    input  logic      expire,
    input  op_class_e cls,
    input  logic      strobe,
    input  logic      at_one,
    output logic      out_lvl
);
    logic fired_q;   // terminal count reached since load or restart
    logic pulse_q;   // one-step strobe window
    logic phase_q;   // square-wave half

    always_ff @(posedge clk) begin
        if (rst) begin
            fired_q <= 1'b1;
            pulse_q <= 1'b0;
            phase_q <= 1'b1;
        end else if (load_stb) begin
            fired_q <= (cls == CLS_TRIGGERED);
            pulse_q <= 1'b0;
            phase_q <= 1'b1;
        end else if (trig) begin
            fired_q <= 1'b0;
            pulse_q <= 1'b0;
            phase_q <= 1'b1;
        end else if (expire) begin
            fired_q <= 1'b1;
            pulse_q <= ~fired_q;
            phase_q <= ~phase_q;
        end else if (step) begin
            pulse_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (cls)
            CLS_ONESHOT, CLS_TRIGGERED: out_lvl = strobe ? ~pulse_q : fired_q;
            CLS_RATE:                   out_lvl = ~at_one;
            CLS_SQUARE:                 out_lvl = phase_q;
            default:                    out_lvl = 1'b1;
        endcase
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic [2:0]       mode,
    input  logic             gate,
    input  logic             irq_mask,
    output logic [CNT_W-1:0] count,
    output logic             out_lvl,
    output logic             irq
);
    op_class_e      cls;
    logic           gate_rise, trig, step, expire;
    logic [CNT_W:0] cnt_full;
    logic           irq_q;

    assign cls  = decode_class(mode);
    assign trig = gate_rise & gate_restarts(cls) & ~load_stb;

    tmr_gate_edge u_gate (
        .clk  (clk),
        .rst  (rst),
        .gate (gate),
        .rise (gate_rise)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .cnt_en   (cnt_en),
        .load_stb (load_stb),
        .load_val (load_val),
        .cls      (cls),
        .gate     (gate),
        .trig     (trig),
        .cnt_full (cnt_full),
        .step     (step),
        .expire   (expire)
    );

    tmr_out_shape u_shape (
        .clk      (clk),
        .rst      (rst),
        .load_stb (load_stb),
        .trig     (trig),
        .step     (step),
        .expire   (expire),
        .cls      (cls),
        .strobe   (is_strobe(mode)),
        .at_one   (cnt_full == {{CNT_W{1'b0}}, 1'b1}),
        .out_lvl  (out_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= out_lvl & ~irq_mask;
    end

    assign count = cnt_full[CNT_W-1:0];
    assign irq   = irq_q;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_en,
    input logic             load_stb,
    input logic [CNT_W-1:0] load_val,
    input logic [2:0]       mode,
    input logic             gate,
    input logic             irq_mask,
    input logic [CNT_W-1:0] count,
    input logic             out_lvl,
    input logic             irq
);
    logic gate_d;
    always_ff @(posedge clk) begin
        if (rst) gate_d <= 1'b1;
        else     gate_d <= gate;
    end

    // R11: mask forces the request low on the next clock
    a_r11_mask_low: assert property (@(posedge clk) disable iff (rst)
        irq_mask |=> !irq);

    // R11: unmasked request tracks the output one clock later
    a_r11_follow: assert property (@(posedge clk) disable iff (rst)
        !irq_mask |=> (irq == $past(out_lvl)));

    // R2: a load places the new value in the count
    a_r2_load_restart: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> (count == $past(load_val)));

    // R8: no enable, no load, no gate edge: count holds
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!load_stb && !cnt_en && !(gate && !gate_d)) |=> $stable(count));

    // R3: code 0 steps down by one with wrap
    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd0 && cnt_en && gate && !load_stb) |=> (count == $past(count) - 1'b1));

    // R9: code 0 output low right after load
    a_r9_low_at_load: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd0 && load_stb) |=> !out_lvl);
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt_en   (cnt_en),
    .load_stb (load_stb),
    .load_val (load_val),
    .mode     (mode),
    .gate     (gate),
    .irq_mask (irq_mask),
    .count    (count),
    .out_lvl  (out_lvl),
    .irq      (irq)
);

// File: tb/tmr_chan_tb.sv
module tmr_chan_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b1;
    logic        load_stb = 1'b0;
    logic [15:0] load_val = '0;
    logic [2:0]  mode = '0;
    logic        gate = 1'b1;
    logic        irq_mask = 1'b0;
    logic [15:0] count;
    logic        out_lvl;
    logic        irq;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    tmr_chan dut_i (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .load_stb(load_stb),
        .load_val(load_val), .mode(mode), .gate(gate), .irq_mask(irq_mask),
        .count(count), .out_lvl(out_lvl), .irq(irq)
    );

    // {mode, load value, steps, expected count, expected out}
    localparam int NV = 13;
    localparam logic [43:0] VEC [NV] = '{
        {3'd0, 16'd10, 8'd3, 16'd7,     1'b0},  // R3 R9
        {3'd0, 16'd3,  8'd3, 16'd0,     1'b1},  // R9
        {3'd0, 16'd0,  8'd1, 16'd65535, 1'b0},  // R1
        {3'd2, 16'd4,  8'd3, 16'd1,     1'b0},  // R4
        {3'd2, 16'd4,  8'd4, 16'd4,     1'b1},  // R4
        {3'd3, 16'd6,  8'd2, 16'd2,     1'b1},  // R5
        {3'd3, 16'd6,  8'd3, 16'd6,     1'b0},  // R5
        {3'd3, 16'd5,  8'd3, 16'd5,     1'b0},  // R5 odd
        {3'd6, 16'd4,  8'd3, 16'd1,     1'b0},  // R6
        {3'd7, 16'd6,  8'd3, 16'd6,     1'b0},  // R6
        {3'd4, 16'd2,  8'd2, 16'd0,     1'b0},  // R10
        {3'd4, 16'd2,  8'd3, 16'd65535, 1'b1},  // R10 R3 wrap
        {3'd1, 16'd5,  8'd2, 16'd3,     1'b1}   // R10 R3
    };

    function automatic string vec_tag(input int i);
        case (i)
            0:       return "R3";
            1:       return "R9";
            2:       return "R1";
            3, 4:    return "R4";
            5, 6, 7: return "R5";
            8, 9:    return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic do_load(input logic [2:0] m, input logic [15:0] v);
        @(negedge clk);
        mode = m; load_val = v; load_stb = 1'b1;
        @(negedge clk);
        load_stb = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                wait_n(20000);
                total++; bad++;
                $display("FAIL watchdog: got timeout expected finish");
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        join_none

        // R12 reset state
        wait_n(3);
        check("R12 count", count, 0);
        check("R12 out", out_lvl, 1);
        check("R12 irq", irq, 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            do_load(VEC[i][43:41], VEC[i][40:25]);
            wait_n(int'(VEC[i][24:17]));
            check({vec_tag(i), " count"}, count, int'(VEC[i][16:1]));
            check({vec_tag(i), " out"}, out_lvl, int'(VEC[i][0]));
        end

        // R8 gate low suspends code 0
        do_load(3'd0, 16'd10);
        gate = 1'b0;
        wait_n(5);
        check("R8 gate hold", count, 10);
        // R7 code 0 gate edge resumes without restart
        gate = 1'b1;
        wait_n(1);
        check("R7 no restart code0", count, 9);

        // R7 code 1 restart, R10 low pulse until terminal count
        do_load(3'd1, 16'd5);
        wait_n(2);
        gate = 1'b0; wait_n(1);
        gate = 1'b1; wait_n(1);
        check("R7 code1 reload", count, 5);
        check("R10 code1 low", out_lvl, 0);
        wait_n(4);
        check("R10 code1 still low", out_lvl, 0);
        wait_n(1);
        check("R10 code1 high at tc", out_lvl, 1);

        // R10 code 5 strobe after restart
        do_load(3'd5, 16'd3);
        gate = 1'b0; wait_n(1);
        gate = 1'b1; wait_n(1);
        wait_n(3);
        check("R10 code5 strobe", out_lvl, 0);
        wait_n(1);
        check("R10 code5 strobe end", out_lvl, 1);

        // R7 code 2 restart after suspend
        do_load(3'd2, 16'd6);
        wait_n(2);
        gate = 1'b0; wait_n(1);
        check("R8 code2 hold", count, 4);
        gate = 1'b1; wait_n(1);
        check("R7 code2 reload", count, 6);

        // R8 enable low holds, R2 reload mid-count
        do_load(3'd2, 16'd100);
        cnt_en = 1'b0;
        wait_n(4);
        check("R8 enable hold", count, 100);
        cnt_en = 1'b1;
        wait_n(3);
        check("R2 running", count, 97);
        do_load(3'd2, 16'd50);
        check("R2 restart", count, 50);

        // R11 mask and release
        do_load(3'd0, 16'd3);
        wait_n(4);
        check("R11 irq follows", irq, 1);
        irq_mask = 1'b1; wait_n(1);
        check("R11 masked", irq, 0);
        check("R11 out kept", out_lvl, 1);
        irq_mask = 1'b0; wait_n(1);
        check("R11 released", irq, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule